// File: doc/BRIEF.md
# Bit-Serial Modular Exponentiator

This block raises an unsigned base to an unsigned power and reduces the result modulo an odd modulus, all operands being `WIDTH` bits wide. It is meant as a small public-key arithmetic engine: software or a sequencer presents the base, the exponent and the modulus, pulses `start`, and collects `result` when `done` pulses.

Inside, one modular multiplier does all the arithmetic. It walks the multiplier operand from its top bit down. At each bit it doubles the running value and adds the multiplicand when the bit is set, and each of these two steps is pulled back under the modulus by a single compare-and-subtract. One product therefore costs one clock per operand bit, with no wide product register and no divider.

A sequencer scans the exponent from its most significant end. It skips the leading zeros and loads the base on the first set bit. For every later bit it squares, and it multiplies by the base when that bit is one, so a `k`-bit exponent costs at most `2k-2` products. Operand handoff is a plain level handshake rather than a stream interface. The operands are sampled only on a cycle where `start` is high and `busy` is low. `busy` stays high until the cycle after `done`. `result` holds its value until the next accepted `start`. The caller must keep the base below the modulus and the modulus odd and greater than 1.

Top module: `modexp_unit`

## Requirements
- R1: After reset `busy` and `done` are 0 and stay 0 while `start` is low.
- R2: For base X < N and odd N > 1, `result` equals X^Y mod N when `done` is 1. This includes N = 3337: 688^79 gives 1570 and 1570^1019 gives 688.
- R3: An exponent of 0 yields `result` = 1 for any base, including base 0.
- R4: The multiplier returns A·B mod N by an MSB-first double-and-add recurrence, so 15·13 mod 23 = 11 and 65534·65534 mod 65535 = 1. Its `done` rises exactly WIDTH+1 clock edges after the edge that samples its `go`, counting that edge.
- R5: `done` is high for exactly one cycle, and `busy` is low in the cycle that follows it. `result` keeps its value until the next accepted `start`.
- R6: A `start` pulse while `busy` is high is ignored. The run in progress returns the result of the operands it accepted, and no new run starts afterwards.
- R7: The leading zero bits of the exponent are skipped, so Y = 1 returns X itself and Y = 2^(WIDTH-1) returns X squared WIDTH-1 times.
- R8: The multiplier keeps its running value below N throughout a product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation; sampled only while `busy` is low |
| x_in | input | WIDTH | Base, below the modulus |
| y_in | input | WIDTH | Exponent |
| n_in | input | WIDTH | Modulus, odd and greater than 1 |
| busy | output | 1 | High from the cycle after an accepted `start` through the `done` cycle |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | WIDTH | X^Y mod N, held until the next accepted `start` |

## Verification
A wrong running value in the multiplier, such as a missed subtraction or a dropped carry, corrupts every later square. It therefore shows up as a wrong `result` at the one `done` pulse of that run, about WIDTH+2 cycles per remaining exponent bit after the fault. A fault in the exponent scan shows up differently: either `done` arrives after the wrong number of cycles, or the result matches a different power. That is why the directed RSA pairs and Y = 0, 1 and 2^(WIDTH-1) are checked next to random operands against a reference computed in the bench. Handshake faults show within one or two cycles of `done`, as a second `done` cycle, as `busy` staying high, or as a start that should have been ignored launching another run.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_NEXT,
    ST_SQW,
    ST_MULW,
    ST_FIN
  } exp_state_t;
endpackage

// File: rtl/modexp_mulser.sv
module modexp_mulser #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] n_in,
  output logic             done,
  output logic [WIDTH-1:0] prod
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] a_q, b_q, n_q, acc;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [WIDTH:0]   dbl, red1, sum, red2, n_ext;

  // one recurrence step: acc <- (2*acc + bit*a) mod n
  always_comb begin
    n_ext = {1'b0, n_q};
    dbl   = {acc, 1'b0};
    red1  = (dbl >= n_ext) ? dbl - n_ext : dbl;
    sum   = red1 + (b_q[WIDTH-1] ? {1'b0, a_q} : '0);
    red2  = (sum >= n_ext) ? sum - n_ext : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      n_q  <= '0;
      acc  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (go) begin
      a_q  <= a_in;
      b_q  <= b_in;
      n_q  <= n_in;
      acc  <= '0;
      cnt  <= '0;
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      acc <= WIDTH'(red2);
      b_q <= b_q << 1;
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign prod = acc;

  // R8: running value stays reduced while a product is in progress
  a_r8_acc_below_n: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc < n_q));
  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: completion only follows an active product
  a_r4_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic [WIDTH-1:0] n_in,
  input  logic             mul_done,
  input  logic [WIDTH-1:0] mul_p,
  output logic             mul_go,
  output logic [WIDTH-1:0] mul_a,
  output logic [WIDTH-1:0] mul_b,
  output logic [WIDTH-1:0] mul_n,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int LW = $clog2(WIDTH + 1);

  exp_state_t       state;
  logic [WIDTH-1:0] x_q, n_q, e_q, res_q;
  logic [LW-1:0]    left;

  always_comb begin
    mul_go = ((state == ST_NEXT) && (left != '0)) ||
             ((state == ST_SQW) && mul_done && e_q[WIDTH-1]);
    mul_a  = (state == ST_SQW) ? x_q   : res_q;
    mul_b  = (state == ST_SQW) ? mul_p : res_q;
    mul_n  = n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      x_q   <= '0;
      n_q   <= '0;
      e_q   <= '0;
      res_q <= '0;
      left  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          x_q   <= x_in;
          n_q   <= n_in;
          e_q   <= y_in;
          res_q <= WIDTH'(1);
          left  <= LW'(WIDTH);
          state <= ST_SKIP;
        end
        ST_SKIP: begin
          if (left == '0) begin
            state <= ST_FIN;
          end else begin
            e_q  <= e_q << 1;
            left <= left - 1'b1;
            if (e_q[WIDTH-1]) begin
              res_q <= x_q;
              state <= ST_NEXT;
            end
          end
        end
        ST_NEXT: state <= (left == '0) ? ST_FIN : ST_SQW;
        ST_SQW: if (mul_done) begin
          res_q <= mul_p;
          e_q   <= e_q << 1;
          left  <= left - 1'b1;
          state <= e_q[WIDTH-1] ? ST_MULW : ST_NEXT;
        end
        ST_MULW: if (mul_done) begin
          res_q <= mul_p;
          state <= ST_NEXT;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);
  assign result = res_q;

  // R5: done is one cycle wide and the unit is free right after it
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5: result is held while idle
  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  // R2: finished value is reduced modulo N
  a_r2_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < n_q));
  // R6: accepted operands do not move during a run
  a_r6_operands_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(n_q) && $stable(x_q)));
  // R4: a product completes only when the sequencer waits for one
  a_r4_done_expected: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done |-> ((state == ST_SQW) || (state == ST_MULW)));
endmodule

// File: rtl/modexp_unit.sv
module modexp_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic [WIDTH-1:0] n_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  logic             mul_go, mul_done;
  logic [WIDTH-1:0] mul_a, mul_b, mul_n, mul_p;

  modexp_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .n_in(n_in),
    .mul_done(mul_done), .mul_p(mul_p),
    .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b), .mul_n(mul_n),
    .busy(busy), .done(done), .result(result)
  );

  modexp_mulser #(.WIDTH(WIDTH)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go),
    .a_in(mul_a), .b_in(mul_b), .n_in(mul_n),
    .done(mul_done), .prod(mul_p)
  );

  // R1: no completion without a run
  a_r1_done_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/modexp_unit_tb.sv
module modexp_unit_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x_in = '0, y_in = '0, n_in = '0;
  logic         busy, done;
  logic [W-1:0] result;

  logic         m_go = 1'b0;
  logic [W-1:0] m_a = '0, m_b = '0, m_n = '0;
  logic         m_done;
  logic [W-1:0] m_p;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  modexp_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .n_in(n_in),
    .busy(busy), .done(done), .result(result)
  );

  modexp_mulser #(.WIDTH(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(m_go),
    .a_in(m_a), .b_in(m_b), .n_in(m_n),
    .done(m_done), .prod(m_p)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_pow(longint x, longint y, longint n);
    longint r = 1 % n;
    for (int i = W - 1; i >= 0; i--) begin
      r = (r * r) % n;
      if (y[i]) r = (r * x) % n;
    end
    return r;
  endfunction

  // one exponentiation; optionally a stray start while busy
  task automatic run_exp(input string req, input longint x, input longint y,
                         input longint n, input bit stray);
    int cyc = 0;
    @(negedge clk);
    x_in = W'(x); y_in = W'(y); n_in = W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " busy after start"}, busy, 1);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (stray && cyc == 30) begin
        x_in = W'(x + 1); y_in = W'(y ^ 3); start = 1'b1;
      end else if (stray && cyc == 31) begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk({req, " result"}, result, ref_pow(x, y, n));
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R5 busy low after done", busy, 0);
    if (stray) begin
      repeat (3) @(negedge clk);
      chk("R6 no new run after ignored start", busy, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy idle", busy, 0);
    chk("R1 done idle", done, 0);
  endtask

  task automatic mul_case(input longint a, input longint b, input longint n);
    @(negedge clk);
    m_a = W'(a); m_b = W'(b); m_n = W'(n); m_go = 1'b1;
    @(negedge clk);
    m_go = 1'b0;
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      if (k == W - 1) chk("R4 mul done not early", m_done, 0);
    end
    @(negedge clk);
    chk("R4 mul done at WIDTH+1 edges", m_done, 1);
    chk("R4 mul product", m_p, (a * b) % n);
    @(negedge clk);
    chk("R4 mul done pulse", m_done, 0);
  endtask

  task automatic t_multiplier();
    mul_case(15, 13, 23);
    mul_case(65534, 65534, 65535);
    mul_case(0, 4321, 65535);
    mul_case(9999, 1, 10007);
  endtask

  task automatic t_rsa();
    run_exp("R2 encrypt", 688, 79, 3337, 0);
    chk("R2 encrypt value", result, 1570);
    run_exp("R2 decrypt", 1570, 1019, 3337, 0);
    chk("R2 decrypt value", result, 688);
  endtask

  task automatic t_zero_exp();
    run_exp("R3 y0", 1234, 0, 40001, 0);
    chk("R3 value one", result, 1);
    run_exp("R3 y0 x0", 0, 0, 3, 0);
    chk("R3 value one base0", result, 1);
  endtask

  task automatic t_leading_zeros();
    run_exp("R7 y1", 4567, 1, 65521, 0);
    chk("R7 y1 is x", result, 4567);
    run_exp("R7 top bit only", 3, 32768, 65521, 0);
    run_exp("R7 all ones", 65000, 65535, 65535, 0);
  endtask

  task automatic t_hold();
    logic [W-1:0] keep;
    run_exp("R5 hold run", 77, 5, 1001, 0);
    keep = result;
    x_in = '1; y_in = '1; n_in = 5;
    repeat (10) @(negedge clk);
    chk("R5 result held", result, keep);
  endtask

  task automatic t_stray_start();
    run_exp("R6 stray start", 31337, 4097, 60001, 1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 30; i++) begin
      longint n, x, y;
      n = longint'($urandom & 32'hFFFF) | 1;
      if (n < 3) n = 3;
      x = longint'($urandom) % n;
      y = longint'($urandom & 32'hFFFF);
      run_exp("R2 random", x, y, n, 0);
    end
  endtask

  initial begin
    t_reset();
    t_multiplier();
    t_rsa();
    t_zero_exp();
    t_leading_zeros();
    t_hold();
    t_stray_start();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule